// File: doc/BRIEF.md
# Indexed-Register Watchdog Timer

This block is a watchdog timer that a host reaches through a two-byte window on a simple byte-wide bus. A write at window offset 0 stores a register index. Reads and writes at offset 1 then reach the register that the stored index selects. The timeout is a 24-bit value spread across three byte registers. A separate tick-enable input advances the countdown, and it is meant to pulse at 32768 Hz. At that rate the longest timeout, 2^24 ticks, lasts 512 seconds.

Software programs the timeout, chooses what happens on expiry, and sets the enable bit. It then requests a reload at regular intervals so that the count never runs out. If the count does run out, a sticky fired flag is set and the block pulses either its reset output or its NMI output for one clock. The counter then reloads and keeps counting while the timer stays enabled. Software clears the fired flag by writing that bit as 0.

Top module: `wdt_index_port`

## Requirements
- R1: A write at offset 0 (`bus_addr`=0) stores an 8-bit index, and a read at offset 0 returns that index. Every read or write at offset 1 reaches the register the stored index selects, until a new index is written.
- R2: After reset all registers read 0x00, the stored index is 0x00, and both event outputs are low.
- R3: Indices 0x39, 0x3A and 0x3B hold timeout bits 7:0, 15:8 and 23:16. These three registers, the control register at index 0x37 and the select register at index 0x38 each read back the full byte last written.
- R4: The count advances only while bit 6 of register 0x37 is 1. Ticks that arrive while the bit is 0 neither change the count nor cause an expiry.
- R5: When bit 6 of register 0x37 changes from 0 to 1, the count loads the programmed timeout N. The expiry then happens on tick N+1.
- R6: Writing 1 to bit 6 of register 0x3C restarts the countdown from the programmed timeout. That bit always reads as 0.
- R7: An expiry sets bit 7 of register 0x3C, and a read does not clear it. Writing the bit as 0 clears it, and writing it as 1 while it is clear leaves it clear.
- R8: On expiry, upper nibble 0xD in register 0x38 gives a one-clock pulse on `rst_event`, and upper nibble 0xC gives a one-clock pulse on `nmi_event`. Any other nibble gives no pulse, but the fired flag is still set. The two outputs are never high together.
- R9: After an expiry the count reloads the timeout, and the next expiry follows another N+1 ticks later if the timer is still enabled.
- R10: Indices other than 0x37 to 0x3C read as 0x00, and writes to them change no register.
- R11: If an expiry and a write that clears the fired flag land on the same clock edge, the flag ends up set. If a reload request and a tick land on the same edge, the reload wins and no expiry occurs on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Countdown tick enable, one clock wide (32768 Hz rate) |
| bus_sel | input | 1 | Window selected for this cycle |
| bus_wr | input | 1 | Write strobe, used when `bus_sel` is high |
| bus_addr | input | 1 | Window offset: 0 for the index, 1 for data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| rst_event | output | 1 | One-clock reset request on expiry |
| nmi_event | output | 1 | One-clock NMI request on expiry |

## Verification
The timer's own expiry can fall on the same clock edge as a host write. Two cases matter: a write that clears the fired flag, and a write that requests a reload. The bench provokes each case by running the count down to zero and then issuing the data write at offset 1 with `tick_en` raised in that same cycle. In the flag case, it judges the result by reading register 0x3C afterwards, which must show the flag still set, and by requiring the event pulse to arrive. In the reload case, it judges the result by the absence of any pulse on that tick and by a full N+1-tick wait before the next pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] IDX_CTRL = 8'h37;
  localparam logic [BYTE_W-1:0] IDX_SEL  = 8'h38;
  localparam logic [BYTE_W-1:0] IDX_TMO0 = 8'h39;
  localparam logic [BYTE_W-1:0] IDX_CMD  = 8'h3C;

  localparam int EN_BIT     = 6;
  localparam int RELOAD_BIT = 6;
  localparam int FIRED_BIT  = 7;

  localparam logic [3:0] ACT_NMI = 4'hC;
  localparam logic [3:0] ACT_RST = 4'hD;

  typedef enum logic [1:0] {EV_NONE = 2'b00, EV_NMI = 2'b01, EV_RST = 2'b10} ev_e;

  function automatic ev_e decode_action(input logic [3:0] nib);
    case (nib)
      ACT_NMI: return EV_NMI;
      ACT_RST: return EV_RST;
      default: return EV_NONE;
    endcase
  endfunction

  function automatic logic fired_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/wdt_host_port.sv
module wdt_host_port
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [BYTE_W-1:0] idx,
  output logic              data_wr,
  output logic [BYTE_W-1:0] bus_rdata
);
  logic idx_wr;

  assign idx_wr  = bus_sel & bus_wr & ~bus_addr;
  assign data_wr = bus_sel & bus_wr &  bus_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (idx_wr) idx <= bus_wdata;
  end

  assign bus_rdata = bus_addr ? reg_rdata : idx;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] idx,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              expire,
  output logic              run,
  output logic              start,
  output logic              reload_req,
  output logic              fired,
  output logic              fired_clr,
  output logic [3:0]        sel_nib,
  output logic [CNT_W-1:0]  timeout,
  output logic [BYTE_W-1:0] rdata
);
  localparam int NB = CNT_W / BYTE_W;

  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] sel_q;
  logic [BYTE_W-1:0] tmo_q [NB];
  logic              hit_ctrl, hit_sel, hit_cmd;

  assign hit_ctrl = data_wr && (idx == IDX_CTRL);
  assign hit_sel  = data_wr && (idx == IDX_SEL);
  assign hit_cmd  = data_wr && (idx == IDX_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      if (hit_ctrl) ctrl_q <= wdata;
      if (hit_sel)  sel_q  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rst_n)
        tmo_q[b] <= '0;
      else if (data_wr && (idx == BYTE_W'(IDX_TMO0 + b)))
        tmo_q[b] <= wdata;
    end
  end

  generate
    for (genvar g = 0; g < NB; g++) begin : g_tmo
      assign timeout[g*BYTE_W +: BYTE_W] = tmo_q[g];
    end
  endgenerate

  assign run        = ctrl_q[EN_BIT];
  assign start      = hit_ctrl & wdata[EN_BIT] & ~ctrl_q[EN_BIT];
  assign reload_req = hit_cmd & wdata[RELOAD_BIT];
  assign fired_clr  = hit_cmd & ~wdata[FIRED_BIT];
  assign sel_nib    = sel_q[7:4];

  always_ff @(posedge clk) begin
    if (!rst_n) fired <= 1'b0;
    else        fired <= fired_next(fired, expire, fired_clr);
  end

  always_comb begin
    rdata = '0;
    if (idx == IDX_CTRL) rdata = ctrl_q;
    if (idx == IDX_SEL)  rdata = sel_q;
    if (idx == IDX_CMD)  rdata[FIRED_BIT] = fired;
    for (int b = 0; b < NB; b++)
      if (idx == BYTE_W'(IDX_TMO0 + b)) rdata = tmo_q[b];
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] timeout,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  logic step;
  assign step   = run & tick_en & ~load;
  assign expire = step & (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (load || expire)  count <= timeout;
    else if (step)            count <= step_down(count);
  end
endmodule

// File: rtl/wdt_event_out.sv
module wdt_event_out
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic [3:0] sel_nib,
  output logic       rst_event,
  output logic       nmi_event
);
  ev_e act;
  assign act = decode_action(sel_nib);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_event <= 1'b0;
      nmi_event <= 1'b0;
    end else begin
      rst_event <= expire && (act == EV_RST);
      nmi_event <= expire && (act == EV_NMI);
    end
  end
endmodule

// File: rtl/wdt_index_port.sv
module wdt_index_port
  import wdt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rst_event,
  output logic       nmi_event
);
  logic [BYTE_W-1:0] idx;
  logic              data_wr;
  logic [BYTE_W-1:0] reg_rdata;
  logic              run, start, reload_req, load;
  logic              fired, fired_clr;
  logic [3:0]        sel_nib;
  logic [CNT_W-1:0]  timeout;
  logic [CNT_W-1:0]  count;
  logic              expire;

  assign load = start | reload_req;

  wdt_host_port u_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .reg_rdata(reg_rdata),
    .idx(idx), .data_wr(data_wr), .bus_rdata(bus_rdata)
  );

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx(idx), .data_wr(data_wr), .wdata(bus_wdata),
    .expire(expire), .run(run), .start(start), .reload_req(reload_req),
    .fired(fired), .fired_clr(fired_clr), .sel_nib(sel_nib),
    .timeout(timeout), .rdata(reg_rdata)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .load(load),
    .timeout(timeout), .count(count), .expire(expire)
  );

  wdt_event_out u_evt (
    .clk(clk), .rst_n(rst_n), .expire(expire), .sel_nib(sel_nib),
    .rst_event(rst_event), .nmi_event(nmi_event)
  );
endmodule

// File: rtl/wdt_index_port_chk.sv
module wdt_index_port_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_event,
  input logic             nmi_event,
  input logic             expire,
  input logic             fired,
  input logic             fired_clr,
  input logic             run,
  input logic             load,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] timeout
);
  // R8
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_event, nmi_event}));

  // R8
  event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_event || nmi_event) |-> $past(expire));

  // R7
  fired_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> fired);

  // R7
  fired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !fired_clr) |=> fired);

  // R9
  reload_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(timeout)));

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(timeout)));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
endmodule

bind wdt_index_port wdt_index_port_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rst_event(rst_event), .nmi_event(nmi_event),
  .expire(expire), .fired(fired), .fired_clr(fired_clr), .run(run),
  .load(load), .count(count), .timeout(timeout)
);

// File: tb/wdt_index_port_tb.sv
module wdt_index_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rst_event, nmi_event;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] ev_q[$];   // expected {rst,nmi}: 2'b10 reset, 2'b01 NMI

  always #10 clk = ~clk;

  wdt_index_port dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_event(rst_event), .nmi_event(nmi_event)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic [7:0] d, input logic t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = t;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] i, input logic [7:0] d);
    cyc(1'b0, i, 1'b0);
    cyc(1'b1, d, 1'b0);
  endtask

  task automatic rreg(input logic [7:0] i, input logic [7:0] exp, input string tag);
    cyc(1'b0, i, 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
    #1 check(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic expect_ev(input logic [1:0] e);
    ev_q.push_back(e);
  endtask

  task automatic drained(input string tag);
    #2;
    checks++;
    if (ev_q.size() != 0) begin
      errors++;
      $display("FAIL %s: got %0d pending events expected 0", tag, ev_q.size());
      ev_q.delete();
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [1:0] got;
    logic [1:0] exp;
    if (rst_n && (rst_event || nmi_event)) begin
      got = {rst_event, nmi_event};
      checks++;
      if (ev_q.size() == 0) begin
        errors++;
        $display("FAIL R8: got event %b expected none", got);
      end else begin
        exp = ev_q.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL R8: got event %b expected %b", got, exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    check("R2 rst_event", {7'b0, rst_event}, 8'h00);
    check("R2 nmi_event", {7'b0, nmi_event}, 8'h00);
    bus_addr = 1'b0; #1 check("R2 index", bus_rdata, 8'h00);
    rreg(8'h37, 8'h00, "R2 ctrl");
    rreg(8'h38, 8'h00, "R2 sel");
    rreg(8'h3C, 8'h00, "R2 cmd");
    // R1 offset 0 read returns index
    cyc(1'b0, 8'h3A, 1'b0);
    @(negedge clk); bus_addr = 1'b0; #1 check("R1 index read", bus_rdata, 8'h3A);
    // R3 byte readback
    wreg(8'h39, 8'hA5); wreg(8'h3A, 8'h5A); wreg(8'h3B, 8'hC3);
    rreg(8'h39, 8'hA5, "R3 tmo lo");
    rreg(8'h3A, 8'h5A, "R3 tmo mid");
    rreg(8'h3B, 8'hC3, "R3 tmo hi");
    wreg(8'h38, 8'hD0);
    rreg(8'h38, 8'hD0, "R3 sel");
    // R1 index persists across data accesses
    cyc(1'b0, 8'h39, 1'b0);
    cyc(1'b1, 8'h03, 1'b0);
    cyc(1'b1, 8'h03, 1'b0);
    @(negedge clk); bus_sel = 1'b1; bus_addr = 1'b1; #1 check("R1 same index", bus_rdata, 8'h03);
    bus_sel = 1'b0;
    wreg(8'h3A, 8'h00); wreg(8'h3B, 8'h00);
    // R10 unimplemented
    wreg(8'h40, 8'hFF); wreg(8'h36, 8'hFF);
    rreg(8'h40, 8'h00, "R10 read 0x40");
    rreg(8'h36, 8'h00, "R10 read 0x36");
    rreg(8'h39, 8'h03, "R10 tmo intact");
    rreg(8'h37, 8'h00, "R10 ctrl intact");
    // R4 disabled ticks
    ticks(5);
    drained("R4 no event while off");
    rreg(8'h3C, 8'h00, "R4 not fired while off");
    // R5 enable loads N=3, expiry on tick 4
    wreg(8'h37, 8'h40);
    ticks(3); drained("R5 early");
    expect_ev(2'b10); ticks(1); drained("R5 expiry at N+1");
    rreg(8'h3C, 8'h80, "R7 fired set");
    rreg(8'h3C, 8'h80, "R7 read keeps fired");
    // R9 continues
    ticks(3); drained("R9 early");
    expect_ev(2'b10); ticks(1); drained("R9 second expiry");
    // R7 clear and no set by 1
    wreg(8'h3C, 8'h00);
    rreg(8'h3C, 8'h00, "R7 cleared");
    wreg(8'h3C, 8'h80);
    rreg(8'h3C, 8'h00, "R7 write 1 no set");
    // R6 reload
    ticks(2);
    wreg(8'h3C, 8'h40);
    rreg(8'h3C, 8'h00, "R6 reload reads 0");
    ticks(3); drained("R6 restarted");
    expect_ev(2'b10); ticks(1); drained("R6 expiry after reload");
    // R4 disable mid-count, R5 rising reload
    ticks(2);
    wreg(8'h37, 8'h00);
    ticks(5); drained("R4 stopped");
    wreg(8'h37, 8'h40);
    ticks(3); drained("R5 re-enable loads");
    expect_ev(2'b10); ticks(1); drained("R5 expiry after re-enable");
    // R8 NMI
    wreg(8'h38, 8'hC0);
    ticks(3);
    expect_ev(2'b01); ticks(1); drained("R8 nmi");
    // R8 other select: no pulse, fired set
    wreg(8'h3C, 8'h00);
    wreg(8'h38, 8'h50);
    ticks(4); drained("R8 no pulse");
    rreg(8'h3C, 8'h80, "R8 fired without pulse");
    // R11 expiry vs fired clear
    wreg(8'h38, 8'hD0);
    cyc(1'b0, 8'h3C, 1'b0);
    ticks(3);
    expect_ev(2'b10);
    cyc(1'b1, 8'h00, 1'b1);
    drained("R11 pulse with clear");
    rreg(8'h3C, 8'h80, "R11 set wins over clear");
    // R11 reload vs tick at zero
    ticks(3);
    cyc(1'b0, 8'h3C, 1'b0);
    cyc(1'b1, 8'hC0, 1'b1);
    drained("R11 reload beats tick");
    ticks(3); drained("R11 full period");
    expect_ev(2'b10); ticks(1); drained("R11 expiry after reload");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule